// File: doc/BRIEF.md
# Fractional-Order PI Speed Controller

This block turns a signed speed error into a speed-loop control command, one result per control sample (nominally 4 kHz). Its default law is a fractional-order PI: a proportional path plus an integral path of non-integer order near 0.494. That integral is built as a backward-difference integrator feeding a seventh-order recursive fractional differentiator of order 0.5058. The differentiator is a separate submodule. A mode input selects an ordinary integer-order PI law for comparison. Both laws share the same integrator.

A sample starts when the strobe is high and no earlier sample is still in the pipeline. The error and the mode are captured at that edge. The result appears with a one-clock valid pulse a fixed number of clocks later. Every data value is two's-complement fixed point with 37 bits in total, 32 of them fractional, so one unit is 2^32 counts. The output clamps at the ends of that range. While the last output was clamped, the integrator holds its value.

Top module: `fopi_speed_ctrl`

## Requirements
- R1: A synchronous reset clears the valid flag, the output, the saturation state, the integrator and all differentiator history. The first sample after reset is computed from an all-zero state.
- R2: The valid flag goes high for exactly one clock. It rises on the third rising edge after the edge that accepted the strobe.
- R3: A strobe seen while an accepted sample is still in flight, in the two clocks after acceptance, is ignored. It starts no sample and changes no state.
- R4: Integrator update on each accepted sample: I = clamp(I_prev + ((TS*e) >>> 30)), where TS = round(0.00025 * 2^30). Every gain and coefficient is a constant scaled by 2^30 and rounded.
- R5: Differentiator output: d = clamp((sum over k=0..7 of W_k*I[n-k] - sum over k=1..7 of A_k*d[n-k]) >>> 30). Its input is the freshly updated integrator value. It updates on every sample in both modes, and its seventh-order numerator and denominator approximate s^0.5058 at a 0.25 ms period.
- R6: With mode input 0 (fractional law), the output is clamp((KP*e + KPKI*d) >>> 30), where KP = round(0.252623*2^30) and KPKI = round(0.252623*3.28026*2^30).
- R7: With mode input 1 (integer law), the output is clamp((KPI*e + KII*I) >>> 30), where KPI = round(0.78521*2^30) and KII = round(10.4586*2^30).
- R8: An out-of-range result clamps to +(2^36 - 1) or -2^36 instead of wrapping.
- R9: When the previous output was clamped, the next accepted sample leaves the integrator unchanged.
- R10: The mode input is used only at the acceptance edge. Changing it while a sample is in flight does not change that sample's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| smp_stb_i | input | 1 | Sample strobe |
| spd_err_i | input | 37 | Signed speed error, 32 fractional bits |
| int_mode_i | input | 1 | 1 selects the integer-order PI law |
| ctrl_o | output | 37 | Signed control output, 32 fractional bits |
| ctrl_vld_o | output | 1 | One-clock pulse when ctrl_o holds a new result |

## Verification
Two events can fall in the same clock. A new strobe can be accepted in the very clock in which valid marks the previous result. That acceptance must then base its integrator freeze decision on the saturation of the result being delivered at that moment. The bench provokes this by chaining samples back to back during long runs of full-scale error, which drive the output into and out of clamping. Each chained result is compared with a bench model that applies the freeze from the previous output. A wrong integrator value then shows up in every later sample.

// File: rtl/fopi_pkg.sv
package fopi_pkg;
  localparam int DW    = 37;          // sample width
  localparam int FW    = 32;          // sample fraction bits
  localparam int CW    = 42;          // coefficient width
  localparam int CF    = 30;          // coefficient fraction bits
  localparam int AW    = DW + CW + 4; // accumulator width
  localparam int NTAPS = 7;           // differentiator order with defined coefficients
  localparam real SCALE = 2.0 ** CF;

  typedef logic signed [DW-1:0] smp_t;
  typedef logic signed [CW-1:0] coef_t;
  typedef logic signed [AW-1:0] acc_t;

  localparam acc_t ACC_HI = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam acc_t ACC_LO = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};
  localparam smp_t SMP_HI = {1'b0, {(DW-1){1'b1}}};
  localparam smp_t SMP_LO = {1'b1, {(DW-1){1'b0}}};

  function automatic coef_t fx(real r);
    longint v;
    v = longint'(r * SCALE);
    return coef_t'(v);
  endfunction

  // feed-forward taps of the s^0.5058 approximation, 0.25 ms period
  function automatic real ff_coef(int k);
    case (k)
      0: return 71.0130967087276;
      1: return -308.361372264005;
      2: return 544.269486732419;
      3: return -498.545074063010;
      4: return 249.992643030789;
      5: return -65.9346494416871;
      6: return 7.82911333155244;
      7: return -0.263186494725346;
      default: return 0.0;
    endcase
  endfunction

  // feedback taps (leading 1 implied)
  function automatic real fb_coef(int k);
    case (k)
      1: return -3.73181345431067;
      2: return 5.44679111687348;
      3: return -3.86873670327290;
      4: return 1.32371721700043;
      5: return -0.164037126272245;
      6: return -0.00750528404544043;
      7: return 0.00161501600045280;
      default: return 0.0;
    endcase
  endfunction

  function automatic acc_t widen(smp_t s);
    return {{(AW-DW){s[DW-1]}}, s};
  endfunction

  function automatic acc_t cmul(coef_t c, smp_t s);
    acc_t a;
    a = {{(AW-CW){c[CW-1]}}, c};
    return a * widen(s);
  endfunction

  function automatic acc_t rescale(acc_t a);
    return a >>> CF;
  endfunction

  function automatic logic out_of_range(acc_t a);
    return (a > ACC_HI) || (a < ACC_LO);
  endfunction

  function automatic smp_t clamp(acc_t a);
    if (a > ACC_HI) return SMP_HI;
    if (a < ACC_LO) return SMP_LO;
    return a[DW-1:0];
  endfunction
endpackage

// File: rtl/fopi_integrator.sv
module fopi_integrator
  import fopi_pkg::*;
#(
  parameter real TS_SEC = 0.00025
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic step_i,
  input  logic hold_i,
  input  smp_t err_i,
  output smp_t integ_o
);
  localparam coef_t TS_C = fx(TS_SEC);

  smp_t integ_q;
  acc_t sum_w;
  logic frozen_w;

  assign frozen_w = step_i && hold_i;
  assign sum_w    = widen(integ_q) + rescale(cmul(TS_C, err_i));

  always_ff @(posedge clk_i) begin
    if (rst_i)                  integ_q <= '0;
    else if (step_i && !hold_i) integ_q <= clamp(sum_w);
  end

  assign integ_o = integ_q;

  a_r9_freeze_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    frozen_w |=> $stable(integ_o));
  a_r1_integ_cleared: assert property (@(posedge clk_i)
    rst_i |=> (integ_o == '0));
endmodule

// File: rtl/fopi_frac_diff.sv
module fopi_frac_diff
  import fopi_pkg::*;
#(
  parameter int ORDER = NTAPS
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic step_i,
  input  smp_t x_i,
  output smp_t y_o
);
  smp_t xs [1:ORDER];
  smp_t ys [1:ORDER];
  smp_t hx [0:ORDER];
  acc_t ff_p [0:ORDER];
  acc_t fb_p [0:ORDER];
  acc_t sum_w;
  smp_t y_new_w;

  assign hx[0] = x_i;

  for (genvar k = 0; k <= ORDER; k++) begin : g_tap
    localparam coef_t WK = fx(ff_coef(k));
    assign ff_p[k] = cmul(WK, hx[k]);
    if (k == 0) begin : g_lead
      assign fb_p[k] = '0;
    end else begin : g_back
      localparam coef_t AK = fx(fb_coef(k));
      assign hx[k]   = xs[k];
      assign fb_p[k] = cmul(AK, ys[k]);
    end
  end

  always_comb begin
    acc_t s;
    s = '0;
    for (int k = 0; k <= ORDER; k++) s = s + ff_p[k] - fb_p[k];
    sum_w = s;
  end

  assign y_new_w = clamp(rescale(sum_w));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int k = 1; k <= ORDER; k++) begin
        xs[k] <= '0;
        ys[k] <= '0;
      end
    end else if (step_i) begin
      xs[1] <= x_i;
      ys[1] <= y_new_w;
      for (int k = 2; k <= ORDER; k++) begin
        xs[k] <= xs[k-1];
        ys[k] <= ys[k-1];
      end
    end
  end

  assign y_o = ys[1];

  a_r5_history_moves: assert property (@(posedge clk_i) disable iff (rst_i)
    step_i |=> (xs[1] == $past(x_i)));
  a_r5_idle_stable: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_i |=> $stable(y_o));
endmodule

// File: rtl/fopi_out_mix.sv
module fopi_out_mix
  import fopi_pkg::*;
#(
  parameter real KP_FRAC = 0.252623,
  parameter real KI_FRAC = 3.28026,
  parameter real KP_INT  = 0.78521,
  parameter real KI_INT  = 10.4586
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic load_i,
  input  logic mode_i,
  input  logic calc_i,
  input  smp_t err_i,
  input  smp_t integ_i,
  input  smp_t frac_i,
  output smp_t u_o,
  output logic sat_o,
  output logic vld_o
);
  localparam coef_t G_P_FRAC = fx(KP_FRAC);
  localparam coef_t G_I_FRAC = fx(KP_FRAC * KI_FRAC);
  localparam coef_t G_P_INT  = fx(KP_INT);
  localparam coef_t G_I_INT  = fx(KI_INT);

  coef_t gp_q, gi_q;
  logic  mode_q;
  smp_t  path_w;
  acc_t  res_w;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gp_q   <= '0;
      gi_q   <= '0;
      mode_q <= 1'b0;
    end else if (load_i) begin
      gp_q   <= mode_i ? G_P_INT : G_P_FRAC;
      gi_q   <= mode_i ? G_I_INT : G_I_FRAC;
      mode_q <= mode_i;
    end
  end

  assign path_w = mode_q ? integ_i : frac_i;
  assign res_w  = rescale(cmul(gp_q, err_i) + cmul(gi_q, path_w));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      u_o   <= '0;
      sat_o <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= calc_i;
      if (calc_i) begin
        u_o   <= clamp(res_w);
        sat_o <= out_of_range(res_w);
      end
    end
  end

  a_r8_clamped_value: assert property (@(posedge clk_i) disable iff (rst_i)
    sat_o |-> (u_o == SMP_HI || u_o == SMP_LO));
  a_r10_gain_stable: assert property (@(posedge clk_i) disable iff (rst_i)
    calc_i |-> $stable(gp_q));
endmodule

// File: rtl/fopi_speed_ctrl.sv
module fopi_speed_ctrl
  import fopi_pkg::*;
#(
  parameter int  ORDER  = NTAPS,
  parameter real TS_SEC = 0.00025
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 smp_stb_i,
  input  logic signed [DW-1:0] spd_err_i,
  input  logic                 int_mode_i,
  output logic signed [DW-1:0] ctrl_o,
  output logic                 ctrl_vld_o
);
  logic s1_v, s2_v, busy_w, accept_w, sat_w;
  smp_t err_q, integ_w, frac_w;

  assign busy_w   = s1_v || s2_v;
  assign accept_w = smp_stb_i && !busy_w;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      s1_v  <= 1'b0;
      s2_v  <= 1'b0;
      err_q <= '0;
    end else begin
      s1_v <= accept_w;
      s2_v <= s1_v;
      if (accept_w) err_q <= spd_err_i;
    end
  end

  fopi_integrator #(.TS_SEC(TS_SEC)) u_integ (
    .clk_i(clk_i), .rst_i(rst_i), .step_i(accept_w), .hold_i(sat_w),
    .err_i(spd_err_i), .integ_o(integ_w)
  );

  fopi_frac_diff #(.ORDER(ORDER)) u_fdiff (
    .clk_i(clk_i), .rst_i(rst_i), .step_i(s1_v), .x_i(integ_w), .y_o(frac_w)
  );

  fopi_out_mix u_mix (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(accept_w), .mode_i(int_mode_i),
    .calc_i(s2_v), .err_i(err_q), .integ_i(integ_w), .frac_i(frac_w),
    .u_o(ctrl_o), .sat_o(sat_w), .vld_o(ctrl_vld_o)
  );

  a_r2_latency: assert property (@(posedge clk_i) disable iff (rst_i)
    accept_w |-> ##3 ctrl_vld_o);
  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    ctrl_vld_o |=> !ctrl_vld_o);
  a_r3_busy_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
    (smp_stb_i && busy_w) |=> !s1_v);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    rst_i |=> (!ctrl_vld_o && ctrl_o == '0));
endmodule

// File: tb/fopi_speed_ctrl_test.sv
module fopi_speed_ctrl_test;
  localparam int PER = 10;
  typedef logic signed [127:0] w_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb = 1'b0;
  logic mode = 1'b0;
  logic signed [36:0] err = '0;
  logic signed [36:0] ctrl;
  logic vld;

  int total = 0;
  int bad = 0;
  int n_sat = 0;
  int n_frz = 0;

  always #(PER/2) clk = ~clk;

  fopi_speed_ctrl uut (
    .clk_i(clk), .rst_i(rst), .smp_stb_i(stb), .spd_err_i(err),
    .int_mode_i(mode), .ctrl_o(ctrl), .ctrl_vld_o(vld)
  );

  // reference model state
  real bw [0:7];
  real ba [0:7];
  w_t mi;
  w_t mx [0:7];
  w_t my [0:7];
  bit msat;

  function automatic w_t q30(real r);
    return w_t'(longint'(r * 1073741824.0));
  endfunction

  function automatic w_t lim(w_t v);
    w_t hi, lo;
    hi = (w_t'(1) <<< 36) - 1;
    lo = -(w_t'(1) <<< 36);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic bit outside(w_t v);
    return v != lim(v);
  endfunction

  task automatic model_clear();
    mi = 0;
    msat = 0;
    for (int k = 0; k < 8; k++) begin
      mx[k] = 0;
      my[k] = 0;
    end
  endtask

  task automatic model_step(input w_t e, input bit m, output w_t u, output bit frz);
    w_t s, r;
    frz = msat;
    if (!msat) mi = lim(mi + ((q30(0.00025) * e) >>> 30));
    for (int k = 7; k > 0; k--) mx[k] = mx[k-1];
    mx[0] = mi;
    s = 0;
    for (int k = 0; k < 8; k++) s = s + q30(bw[k]) * mx[k];
    for (int k = 1; k < 8; k++) s = s - q30(ba[k]) * my[k];
    for (int k = 7; k > 1; k--) my[k] = my[k-1];
    my[1] = lim(s >>> 30);
    if (m) r = (q30(0.78521) * e + q30(10.4586) * mi) >>> 30;
    else   r = (q30(0.252623) * e + q30(0.252623 * 3.28026) * my[1]) >>> 30;
    u = lim(r);
    msat = outside(r);
  endtask

  task automatic check(input bit ok, input string tag, input w_t act, input w_t exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // noisy: extra strobes and mode flip while in flight; chain: start on current negedge
  task automatic run_sample(input logic signed [36:0] e, input bit m, input bit noisy, input bit chain);
    w_t exp;
    bit frz;
    string tag;
    if (!chain) @(negedge clk);
    stb = 1'b1; err = e; mode = m;
    model_step(w_t'(e), m, exp, frz);
    if (frz) n_frz++;
    if (msat) n_sat++;
    @(negedge clk);
    check(vld == 1'b0, "R2 early valid", w_t'(vld), 0);
    stb = noisy; err = ~e;
    if (noisy) mode = ~m;
    @(negedge clk);
    check(vld == 1'b0, "R2 early valid", w_t'(vld), 0);
    stb = noisy;
    @(negedge clk);
    stb = 1'b0;
    check(vld == 1'b1, "R2 valid on third edge", w_t'(vld), 1);
    if (msat)       tag = "R8 clamp";
    else if (frz)   tag = "R9 freeze";
    else if (noisy) tag = "R3 R10 in-flight strobe/mode";
    else if (m)     tag = "R4 R7 integer law";
    else            tag = "R4 R5 R6 fractional law";
    check(w_t'(ctrl) == exp, tag, w_t'(ctrl), exp);
  endtask

  function automatic logic signed [36:0] rnd_err();
    logic signed [63:0] r;
    r = {$urandom, $urandom};
    return 37'(r >>> 29);
  endfunction

  initial begin
    #(PER * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bw[0] = 71.0130967087276;   bw[1] = -308.361372264005;
    bw[2] = 544.269486732419;   bw[3] = -498.545074063010;
    bw[4] = 249.992643030789;   bw[5] = -65.9346494416871;
    bw[6] = 7.82911333155244;   bw[7] = -0.263186494725346;
    ba[0] = 1.0;                ba[1] = -3.73181345431067;
    ba[2] = 5.44679111687348;   ba[3] = -3.86873670327290;
    ba[4] = 1.32371721700043;   ba[5] = -0.164037126272245;
    ba[6] = -0.00750528404544043; ba[7] = 0.00161501600045280;
    model_clear();
    void'($urandom(32'd4242));

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(vld == 1'b0, "R1 reset valid", w_t'(vld), 0);
    check(ctrl == '0, "R1 reset output", w_t'(ctrl), 0);

    // directed
    run_sample(37'sd0, 1'b0, 1'b0, 1'b0);
    run_sample(37'sd1 <<< 32, 1'b0, 1'b0, 1'b0);
    run_sample(-(37'sd1 <<< 32), 1'b1, 1'b0, 1'b0);
    run_sample(37'sd3 <<< 31, 1'b0, 1'b1, 1'b0);
    run_sample(-(37'sd5 <<< 30), 1'b1, 1'b1, 1'b0);

    // random mix
    for (int i = 0; i < 300; i++)
      run_sample(rnd_err(), 1'($urandom % 2), ($urandom % 5) == 0, ($urandom % 3) == 0);

    // drive into clamp and back, chained
    for (int i = 0; i < 160; i++)
      run_sample({1'b0, {36{1'b1}}}, 1'b1, 1'b0, (i % 2) == 1);
    for (int i = 0; i < 320; i++)
      run_sample({1'b1, {36{1'b0}}}, 1'($urandom % 2), 1'b0, (i % 2) == 1);
    for (int i = 0; i < 120; i++)
      run_sample({1'b0, {36{1'b1}}}, 1'b0, ($urandom % 4) == 0, 1'b1);

    check(n_sat > 0, "R8 clamp reached", w_t'(n_sat), 1);
    check(n_frz > 0, "R9 freeze reached", w_t'(n_frz), 1);

    // reset mid-run then restart from zero state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    check(vld == 1'b0, "R1 reset valid after run", w_t'(vld), 0);
    check(ctrl == '0, "R1 reset output after run", w_t'(ctrl), 0);
    run_sample(37'sd1 <<< 32, 1'b0, 1'b0, 1'b0);
    run_sample(37'sd1 <<< 32, 1'b1, 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule